// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Controller

This block gathers sixteen level-sensitive interrupt lines from local peripherals into one interrupt request. Each line drives its own pending bit, which simply mirrors the line's level. A software-visible enable mask selects which pending bits may reach the output. The registered output `irqOut` is high whenever at least one enabled line is pending.

A processor services the request through a small memory-mapped register window. The window holds two halfword registers. Offset 0 is a read-only vector. It returns the index of the lowest-numbered enabled pending line, plus one, shifted left by two, so that it can index a table of four-byte entries directly. Offset 2 is the enable mask, which can be read and written.

The window supports byte, halfword and word accesses. A byte write updates only the addressed byte of a halfword. A word access is split into two halfword accesses, one at the addressed offset and one two bytes above it.

Top module: `lbirq_top`

## Requirements
- R1: Pending bit i takes the level of `srcLevel[i]` sampled at each rising clock edge. A line that goes high sets its bit, and a line that goes low clears it one clock later.
- R2: `irqOut` is high exactly when (pending AND mask) is non-zero. It is registered, so it follows a source change or a mask write at the same clock edge that updates the pending bits or the mask.
- R3: A halfword read at offset 0 returns ((i+1) << 2), where i is the lowest set bit of (pending AND mask). It returns 0 when no bit is set.
- R4: Offset 0 is read-only. Writes to it, of any size, leave the mask unchanged.
- R5: Offset 2 holds the 16-bit enable mask. A halfword write there loads `busWdata[15:0]`, and a halfword read returns the mask.
- R6: After reset the mask is 0x0010, all pending bits are 0 and `irqOut` is 0.
- R7: A byte access (`busSize` = 0) targets the halfword at the address with bit 0 cleared. Address bit 0 = 1 selects bits 15:8 and bit 0 = 0 selects bits 7:0. A byte read returns that byte in `busRdata[7:0]` with the upper bits zero. A byte write replaces only that byte with `busWdata[7:0]` and keeps the other byte.
- R8: A word access (`busSize` = 2) at halfword address a reads {half(a+2), half(a)}. A word write is the same as a halfword write of `busWdata[15:0]` to a followed by a halfword write of `busWdata[31:16]` to a+2. `busSize` = 1 is a halfword access and `busSize` = 3 does nothing.
- R9: Reads of any halfword offset other than 0 and 2 return 0. Writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srcLevel | input | 16 | Interrupt source levels, one per line |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | 0 byte, 1 halfword, 2 word |
| busAddr | input | 12 | Byte offset within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, 0 when not reading |
| irqOut | output | 1 | Registered aggregated interrupt request |

## Verification
The assertions assume that a bus access lasts exactly one clock. They also assume that `srcLevel` and the bus inputs are stable around each rising edge, so the registered state is a clean function of the sampled values.

The bench meets these assumptions by changing every input on the falling edge. It also holds each access for a single cycle. It samples combinational read data shortly after driving the address and samples `irqOut` half a clock after the edge.

Every masked and pending pattern in the bench is chosen so that the lowest-set-bit encoding is unambiguous. The patterns include the lowest line, the highest line, and cases where no enabled line is pending.

// File: rtl/lbirq_pkg.sv
package lbirq_pkg;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;
  localparam int LANES  = HALF_W / BYTE_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic              maskWr;
    logic [LANES-1:0]  laneEn;
    logic [HALF_W-1:0] wdata;
  } strobe_t;
endpackage

// File: rtl/lbirq_datapath.sv
module lbirq_datapath
  import lbirq_pkg::*;
#(
  parameter int              NUM_SRC    = 16,
  parameter logic [HALF_W-1:0] MASK_RESET = 16'h0010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  strobe_t            strobe,
  output logic               irqOut,
  output logic [HALF_W-1:0]  statusHalf,
  output logic [HALF_W-1:0]  maskHalf
);
  logic [NUM_SRC-1:0] pendReg;
  logic [HALF_W-1:0]  maskReg;
  logic [HALF_W-1:0]  maskNext;
  logic [NUM_SRC-1:0] enabled;
  logic               pastValid;

  // Byte-lane merge: unaddressed lanes keep the current mask (read-modify-write)
  always_comb begin
    maskNext = maskReg;
    for (int b = 0; b < LANES; b++) begin
      if (strobe.maskWr && strobe.laneEn[b]) begin
        maskNext[b*BYTE_W +: BYTE_W] = strobe.wdata[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendReg   <= '0;
      maskReg   <= MASK_RESET;
      irqOut    <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      pendReg   <= srcLevel;
      maskReg   <= maskNext;
      irqOut    <= |(srcLevel & maskNext[NUM_SRC-1:0]);
      pastValid <= 1'b1;
    end
  end

  assign enabled  = pendReg & maskReg[NUM_SRC-1:0];
  assign maskHalf = maskReg;

  // Lowest enabled pending index wins
  always_comb begin
    statusHalf = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (enabled[i]) begin
        statusHalf = HALF_W'((i + 1) << 2);
      end
    end
  end

  // R1
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid |-> (pendReg == $past(srcLevel)));

  // R2
  irq_vs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut == (statusHalf != '0));

  // R3
  status_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statusHalf[1:0] == 2'b00) && (statusHalf <= HALF_W'(NUM_SRC * 4)));

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && !strobe.maskWr) |=> $stable(maskReg));
endmodule

// File: rtl/lbirq_control.sv
module lbirq_control
  import lbirq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic [HALF_W-1:0] statusHalf,
  input  logic [HALF_W-1:0] maskHalf,
  output strobe_t           strobe,
  output logic [BUS_W-1:0]  busRdata
);
  localparam logic [ADDR_W-1:0] STATUS_OFF = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] MASK_OFF   = ADDR_W'(2);

  acc_size_e         accSize;
  logic [ADDR_W-1:0] halfA;
  logic [ADDR_W-1:0] halfB;
  logic              doWr;

  assign accSize = acc_size_e'(busSize);
  assign halfA   = {busAddr[ADDR_W-1:1], 1'b0};
  assign halfB   = halfA + ADDR_W'(2);
  assign doWr    = busSel && busWrite;

  function automatic logic [HALF_W-1:0] halfRead(input logic [ADDR_W-1:0] a,
                                                 input logic [HALF_W-1:0] st,
                                                 input logic [HALF_W-1:0] mk);
    if (a == STATUS_OFF)    return st;
    else if (a == MASK_OFF) return mk;
    else                    return '0;
  endfunction

  always_comb begin
    strobe = '0;
    if (doWr) begin
      unique case (accSize)
        SZ_BYTE: if (halfA == MASK_OFF) begin
          strobe.maskWr = 1'b1;
          strobe.laneEn = busAddr[0] ? 2'b10 : 2'b01;
          strobe.wdata  = {busWdata[BYTE_W-1:0], busWdata[BYTE_W-1:0]};
        end
        SZ_HALF: if (halfA == MASK_OFF) begin
          strobe.maskWr = 1'b1;
          strobe.laneEn = '1;
          strobe.wdata  = busWdata[HALF_W-1:0];
        end
        SZ_WORD: begin
          if (halfA == MASK_OFF) begin
            strobe.maskWr = 1'b1;
            strobe.laneEn = '1;
            strobe.wdata  = busWdata[HALF_W-1:0];
          end else if (halfB == MASK_OFF) begin
            strobe.maskWr = 1'b1;
            strobe.laneEn = '1;
            strobe.wdata  = busWdata[2*HALF_W-1:HALF_W];
          end
        end
        default: strobe = '0;
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite) begin
      unique case (accSize)
        SZ_BYTE: begin
          logic [HALF_W-1:0] h;
          h = halfRead(halfA, statusHalf, maskHalf);
          busRdata = BUS_W'(busAddr[0] ? h[HALF_W-1:BYTE_W] : h[BYTE_W-1:0]);
        end
        SZ_HALF: busRdata = BUS_W'(halfRead(halfA, statusHalf, maskHalf));
        SZ_WORD: busRdata = {halfRead(halfB, statusHalf, maskHalf),
                             halfRead(halfA, statusHalf, maskHalf)};
        default: busRdata = '0;
      endcase
    end
  end

  // R7
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.maskWr && accSize == SZ_BYTE) |-> ($countones(strobe.laneEn) == 1));

  // R4
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doWr && accSize != SZ_WORD && halfA == STATUS_OFF) |-> !strobe.maskWr);

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doWr && halfA != MASK_OFF && halfB != MASK_OFF) |-> !strobe.maskWr);
endmodule

// File: rtl/lbirq_top.sv
module lbirq_top
  import lbirq_pkg::*;
#(
  parameter int          NUM_SRC    = 16,
  parameter int          ADDR_W     = 12,
  parameter int          BUS_W      = 32,
  parameter logic [15:0] MASK_RESET = 16'h0010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [1:0]         busSize,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BUS_W-1:0]   busWdata,
  output logic [BUS_W-1:0]   busRdata,
  output logic               irqOut
);
  strobe_t           strobe;
  logic [HALF_W-1:0] statusHalf;
  logic [HALF_W-1:0] maskHalf;

  lbirq_control #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) i_ctl (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWrite(busWrite),
    .busSize(busSize), .busAddr(busAddr), .busWdata(busWdata),
    .statusHalf(statusHalf), .maskHalf(maskHalf),
    .strobe(strobe), .busRdata(busRdata)
  );

  lbirq_datapath #(.NUM_SRC(NUM_SRC), .MASK_RESET(MASK_RESET)) i_dp (
    .clk(clk), .rst_n(rst_n), .srcLevel(srcLevel), .strobe(strobe),
    .irqOut(irqOut), .statusHalf(statusHalf), .maskHalf(maskHalf)
  );
endmodule

// File: tb/test_lbirq_top.sv
`timescale 1ns/1ps
module test_lbirq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] srcLevel = '0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busSize = 2'd1;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  lbirq_top i_lbirq_top (
    .clk(clk), .rst_n(rst_n), .srcLevel(srcLevel), .busSel(busSel),
    .busWrite(busWrite), .busSize(busSize), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  // {mask, src, expected status, expected irq}
  localparam logic [48:0] VECS [8] = '{
    {16'hFFFF, 16'h0001, 16'h0004, 1'b1},
    {16'hFFFF, 16'h8000, 16'h0040, 1'b1},
    {16'h00F0, 16'h0F0F, 16'h0000, 1'b0},
    {16'h00F0, 16'h0FF0, 16'h0014, 1'b1},
    {16'h8001, 16'hFFFE, 16'h0040, 1'b1},
    {16'h0000, 16'hFFFF, 16'h0000, 1'b0},
    {16'h0C00, 16'h0800, 16'h0030, 1'b1},
    {16'h0006, 16'h0006, 16'h0008, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] sz, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busSize = sz; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] sz, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busSize = sz; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 reset state
    check("R6 irq", {31'd0, irqOut}, 32'd0);
    busRd(2'd1, 12'h002, rd); check("R6 mask", rd, 32'h0010);
    busRd(2'd1, 12'h000, rd); check("R6 status", rd, 32'h0000);

    // R6 default mask enables line 4 only
    srcLevel = 16'h0020;
    @(negedge clk); check("R6 masked line", {31'd0, irqOut}, 32'd0);
    srcLevel = 16'h0010;
    #1 check("R2 latency before edge", {31'd0, irqOut}, 32'd0);
    @(negedge clk); check("R2 irq after edge", {31'd0, irqOut}, 32'd1);
    busRd(2'd1, 12'h000, rd); check("R3 line4", rd, 32'h0014);

    // R1 line drop clears pending
    srcLevel = 16'h0000;
    @(negedge clk); check("R1 drop irq", {31'd0, irqOut}, 32'd0);
    busRd(2'd1, 12'h000, rd); check("R1 drop status", rd, 32'h0000);

    // Table walk: R5 mask write, R3 encoding, R2 irq
    for (int k = 0; k < 8; k++) begin
      busWr(2'd1, 12'h002, {16'h0, VECS[k][48:33]});
      srcLevel = VECS[k][32:17];
      @(negedge clk);
      check("R2 table irq", {31'd0, irqOut}, {31'd0, VECS[k][0]});
      busRd(2'd1, 12'h000, rd); check("R3 table status", rd, {16'h0, VECS[k][16:1]});
      busRd(2'd1, 12'h002, rd); check("R5 table mask", rd, {16'h0, VECS[k][48:33]});
    end

    // R2 mask write alone drops irq on next edge
    busWr(2'd1, 12'h002, 32'h0000_0002);
    check("R2 mask write drop", {31'd0, irqOut}, 32'd1);
    @(negedge clk);
    busWr(2'd1, 12'h002, 32'h0000_0000);
    check("R2 mask cleared", {31'd0, irqOut}, 32'd0);
    srcLevel = 16'h0000;

    // R7 byte write/read
    busWr(2'd1, 12'h002, 32'h0000_0010);
    busWr(2'd0, 12'h003, 32'h0000_00AB);
    busRd(2'd1, 12'h002, rd); check("R7 high byte write", rd, 32'h0000_AB10);
    busWr(2'd0, 12'h002, 32'h0000_00CD);
    busRd(2'd1, 12'h002, rd); check("R7 low byte write", rd, 32'h0000_ABCD);
    busRd(2'd0, 12'h003, rd); check("R7 byte read hi", rd, 32'h0000_00AB);
    busRd(2'd0, 12'h002, rd); check("R7 byte read lo", rd, 32'h0000_00CD);

    // R4 status read-only
    busWr(2'd1, 12'h000, 32'h0000_FFFF);
    busWr(2'd0, 12'h001, 32'h0000_0055);
    busRd(2'd1, 12'h002, rd); check("R4 status write ignored", rd, 32'h0000_ABCD);

    // R8 word write at 0 lands upper half in mask
    busWr(2'd2, 12'h000, 32'h1234_5678);
    busRd(2'd1, 12'h002, rd); check("R8 word write at 0", rd, 32'h0000_1234);
    busWr(2'd2, 12'h002, 32'h9999_0204);
    busRd(2'd1, 12'h002, rd); check("R8 word write at 2", rd, 32'h0000_0204);
    srcLevel = 16'h0004;
    @(negedge clk);
    busRd(2'd2, 12'h000, rd); check("R8 word read at 0", rd, 32'h0204_000C);
    busRd(2'd2, 12'h002, rd); check("R8 word read at 2", rd, 32'h0000_0204);
    busWr(2'd3, 12'h002, 32'h0000_FFFF);
    busRd(2'd1, 12'h002, rd); check("R8 size 3 no-op", rd, 32'h0000_0204);

    // R9 unmapped
    busWr(2'd1, 12'h010, 32'h0000_FFFF);
    busWr(2'd0, 12'h005, 32'h0000_00FF);
    busRd(2'd1, 12'h002, rd); check("R9 unmapped write ignored", rd, 32'h0000_0204);
    busRd(2'd1, 12'h010, rd); check("R9 unmapped read", rd, 32'h0000_0000);
    busRd(2'd0, 12'h7FF, rd); check("R9 unmapped byte read", rd, 32'h0000_0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule